// File: doc/BRIEF.md
# MAC Interrupt Vector Unit

This block gathers completion pulses from a bank of transmit channels and a bank of receive channels, along with a host-error pulse and a status pulse. Each pulse sets a pending flag. The flag stays set until software writes the acknowledge word for that source. A per-source enable gates which pending flags may interrupt. Every enable register has two write words: one sets bits and one clears bits.

Software reads one vector word. It contains a flag for each source class that has an enabled pending source, the number of the lowest enabled pending transmit channel, and the number of the lowest enabled pending receive channel. The interrupt line rises when any enabled source is pending. It then stays high, even if the sources are acknowledged, until software writes the end-of-interrupt word.

The register bus is word addressed. Writes are single-cycle strobes. Read data is combinational from the address.

Top module: `mac_irq_vector`

## Requirements
- R1: After reset, all enables and pending flags are zero, the vector reads 0 and `irq` is low.
- R2: Vector bit 16 is set when an enabled transmit channel is pending. Vector bits [2:0] then hold the lowest such channel number; otherwise they are 0.
- R3: Vector bit 17 is set when an enabled receive channel is pending. Vector bits [10:8] then hold the lowest such channel number; otherwise they are 0.
- R4: Vector bit 18 reports a pending host error enabled by MAC enable bit 0. Vector bit 19 reports a pending status event enabled by MAC enable bit 1. Writing 3 to word 4 enables both.
- R5: Enable words are: transmit set 0 and clear 1, receive set 2 and clear 3, MAC set 4 and clear 5. A set word ORs the written ones into the enable. A clear word removes the written ones. Zero bits have no effect. Reading any of the pair returns that enable. Writing 0xFF to a clear word disables all 8 channels.
- R6: An event on a disabled source stays pending. It appears in the vector and raises `irq` once the source is enabled.
- R7: Once `irq` is high, it stays high until a write to word 7, the end-of-interrupt word, whatever the pending state.
- R8: A write of any value to word 7 drops `irq` on the next cycle. `irq` asserts again one cycle later if an enabled source is still pending.
- R9: A write of any value to word 16+c clears transmit channel c pending. A write to word 24+c clears receive channel c pending. No other flag changes. An event arriving in the same cycle as its acknowledge keeps the flag set.
- R10: Writing word 8 clears the host-error pending flag where data bit 0 is 1, and the status pending flag where data bit 1 is 1.
- R11: Word 6 reads the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW (6) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tx_done | input | NCH (8) | Transmit completion pulses, one per channel |
| rx_done | input | NCH (8) | Receive completion pulses, one per channel |
| host_err | input | 1 | Host error pulse |
| stat_evt | input | 1 | Status event pulse |
| irq | output | 1 | Level interrupt output |

## Verification
The bench uses the default build: eight channels per direction and a six-bit word address. With this build the channel fields use all three bits, so channel 7 and ties among many pending channels can be reached. The acknowledge words for both banks also fit in the map.

Random bursts of events, enable writes, acknowledges and end-of-interrupt writes run against a cycle model of the bench's own. Directed cases cover:
- an event arriving at the same time as its acknowledge;
- end-of-interrupt while sources are still pending;
- events recorded while a source is disabled.

// File: rtl/mac_irq_vector_pkg.sv
package mac_irq_vector_pkg;
  localparam int W_TX_EN_SET  = 0;
  localparam int W_TX_EN_CLR  = 1;
  localparam int W_RX_EN_SET  = 2;
  localparam int W_RX_EN_CLR  = 3;
  localparam int W_MAC_EN_SET = 4;
  localparam int W_MAC_EN_CLR = 5;
  localparam int W_VECTOR     = 6;
  localparam int W_EOI        = 7;
  localparam int W_MAC_ACK    = 8;
  localparam int W_ACK_BASE   = 16;

  localparam int VB_TX   = 16;
  localparam int VB_RX   = 17;
  localparam int VB_HOST = 18;
  localparam int VB_STAT = 19;
  localparam int VF_RX   = 8;

  typedef logic [31:0] word_t;

  // Assemble the summarized vector word from class flags and channel fields.
  function automatic word_t pack_vector(input logic tx_any, input logic [7:0] tx_ch,
                                        input logic rx_any, input logic [7:0] rx_ch,
                                        input logic host, input logic stat);
    word_t v;
    v = '0;
    v[7:0]              = tx_any ? tx_ch : 8'd0;
    v[VF_RX +: 8]       = rx_any ? rx_ch : 8'd0;
    v[VB_TX]            = tx_any;
    v[VB_RX]            = rx_any;
    v[VB_HOST]          = host;
    v[VB_STAT]          = stat;
    return v;
  endfunction

  // Mask of all bit positions strictly below idx.
  function automatic logic [31:0] below_mask(input int unsigned idx);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < idx);
    return m;
  endfunction
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_wr,
  input  logic         clr_wr,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] en
);
  logic [W-1:0] set_bits, clr_bits;
  assign set_bits = set_wr ? wmask : '0;
  assign clr_bits = clr_wr ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else        en <= (en | set_bits) & ~clr_bits;
  end

  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((en & $past(wmask)) == $past(wmask)));
  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((en & $past(wmask)) == '0));
  // R5
  en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wr && !clr_wr) |=> $stable(en));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] ack,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~ack) | evt;
  end

  // R6
  pend_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));
  // R9
  pend_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~evt) != '0) |=> ((pend & $past(ack & ~evt)) == '0));
  // R9
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(ack)) == ($past(pend) & ~$past(ack)) | ($past(evt) & ~$past(ack))));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  import mac_irq_vector_pkg::*;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign valid = |req;

  logic [31:0] req_wide;
  assign req_wide = 32'(req);

  // R2
  lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (req[idx] && ((req_wide & below_mask(32'(idx))) == '0)));
  // R3
  none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (idx == '0));
endmodule

// File: rtl/mac_irq_vector.sv
module mac_irq_vector #(
  parameter int NCH = 8,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] tx_done,
  input  logic [NCH-1:0] rx_done,
  input  logic           host_err,
  input  logic           stat_evt,
  output logic           irq
);
  import mac_irq_vector_pkg::*;

  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int TX_ACK0  = W_ACK_BASE;
  localparam int RX_ACK0  = W_ACK_BASE + NCH;
  localparam int NBANK    = 2;

  // Decoded write strobes
  logic wr_tx_set, wr_tx_clr, wr_rx_set, wr_rx_clr, wr_mac_set, wr_mac_clr;
  logic wr_eoi, wr_mac_ack;
  assign wr_tx_set  = bus_wr && (bus_addr == AW'(W_TX_EN_SET));
  assign wr_tx_clr  = bus_wr && (bus_addr == AW'(W_TX_EN_CLR));
  assign wr_rx_set  = bus_wr && (bus_addr == AW'(W_RX_EN_SET));
  assign wr_rx_clr  = bus_wr && (bus_addr == AW'(W_RX_EN_CLR));
  assign wr_mac_set = bus_wr && (bus_addr == AW'(W_MAC_EN_SET));
  assign wr_mac_clr = bus_wr && (bus_addr == AW'(W_MAC_EN_CLR));
  assign wr_eoi     = bus_wr && (bus_addr == AW'(W_EOI));
  assign wr_mac_ack = bus_wr && (bus_addr == AW'(W_MAC_ACK));

  logic [NCH-1:0] tx_ack, rx_ack;
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ack
      assign tx_ack[c] = bus_wr && (bus_addr == AW'(TX_ACK0 + c));
      assign rx_ack[c] = bus_wr && (bus_addr == AW'(RX_ACK0 + c));
    end
  endgenerate

  // Per-channel banks: index 0 transmit, index 1 receive
  logic [NCH-1:0] bank_en   [NBANK];
  logic [NCH-1:0] bank_pend [NBANK];
  logic [NCH-1:0] bank_act  [NBANK];
  logic           bank_any  [NBANK];
  logic [CHW-1:0] bank_ch   [NBANK];
  logic           bank_set  [NBANK];
  logic           bank_clr  [NBANK];
  logic [NCH-1:0] bank_evt  [NBANK];
  logic [NCH-1:0] bank_ack  [NBANK];

  assign bank_set[0] = wr_tx_set;
  assign bank_clr[0] = wr_tx_clr;
  assign bank_evt[0] = tx_done;
  assign bank_ack[0] = tx_ack;
  assign bank_set[1] = wr_rx_set;
  assign bank_clr[1] = wr_rx_clr;
  assign bank_evt[1] = rx_done;
  assign bank_ack[1] = rx_ack;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      irq_enable_reg #(.W(NCH)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (bank_set[b]),
        .clr_wr (bank_clr[b]),
        .wmask  (bus_wdata[NCH-1:0]),
        .en     (bank_en[b])
      );
      irq_pend_bank #(.W(NCH)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (bank_evt[b]),
        .ack   (bank_ack[b]),
        .pend  (bank_pend[b])
      );
      assign bank_act[b] = bank_pend[b] & bank_en[b];
      irq_prio_enc #(.N(NCH), .IW(CHW)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (bank_act[b]),
        .valid (bank_any[b]),
        .idx   (bank_ch[b])
      );
    end
  endgenerate

  // MAC-level sources: bit 0 host error, bit 1 status
  logic [1:0] mac_en, mac_pend, mac_act;
  irq_enable_reg #(.W(2)) u_mac_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (wr_mac_set),
    .clr_wr (wr_mac_clr),
    .wmask  (bus_wdata[1:0]),
    .en     (mac_en)
  );
  irq_pend_bank #(.W(2)) u_mac_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   ({stat_evt, host_err}),
    .ack   (wr_mac_ack ? bus_wdata[1:0] : 2'b00),
    .pend  (mac_pend)
  );
  assign mac_act = mac_pend & mac_en;

  // Summary vector and activity
  logic [31:0] vec;
  logic        any_active;
  assign vec = pack_vector(bank_any[0], 8'(bank_ch[0]), bank_any[1], 8'(bank_ch[1]),
                           mac_act[0], mac_act[1]);
  assign any_active = bank_any[0] | bank_any[1] | (|mac_act);

  // Latched interrupt line, released only by end-of-interrupt
  logic irq_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (wr_eoi) irq_q <= 1'b0;
    else if (irq_q)  irq_q <= 1'b1;
    else             irq_q <= any_active;
  end
  assign irq = irq_q;

  // Register read mux
  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      W_TX_EN_SET, W_TX_EN_CLR:   bus_rdata = 32'(bank_en[0]);
      W_RX_EN_SET, W_RX_EN_CLR:   bus_rdata = 32'(bank_en[1]);
      W_MAC_EN_SET, W_MAC_EN_CLR: bus_rdata = 32'(mac_en);
      W_VECTOR:                   bus_rdata = vec;
      default:                    bus_rdata = '0;
    endcase
  end

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_eoi) |=> irq);
  // R8
  eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eoi |=> !irq);
  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && any_active && !wr_eoi) |=> irq);
  // R4
  host_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_pend[0] && mac_en[0]) |-> vec[VB_HOST]);
  // R6
  rise_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_active));
endmodule

// File: tb/mac_irq_vector_tb.sv
module mac_irq_vector_tb;
  localparam int NCH = 8;
  localparam int AW  = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] tx_done = '0;
  logic [NCH-1:0] rx_done = '0;
  logic           host_err = 1'b0;
  logic           stat_evt = 1'b0;
  logic           irq;

  always #5 clk = ~clk;

  mac_irq_vector #(.NCH(NCH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_done(tx_done),
    .rx_done(rx_done), .host_err(host_err), .stat_evt(stat_evt), .irq(irq)
  );

  int checks = 0;
  int failures = 0;

  // Bench model
  logic [7:0] m_txe = 0, m_rxe = 0, m_txp = 0, m_rxp = 0;
  logic [1:0] m_mace = 0, m_macp = 0;
  logic       m_irq = 0;

  function automatic int first_set(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] exp_vec();
    logic [31:0] v = 0;
    logic [7:0] ta = m_txp & m_txe;
    logic [7:0] ra = m_rxp & m_rxe;
    if (ta != 0) begin v[16] = 1; v[2:0] = 3'(first_set(ta)); end
    if (ra != 0) begin v[17] = 1; v[10:8] = 3'(first_set(ra)); end
    v[18] = m_macp[0] & m_mace[0];
    v[19] = m_macp[1] & m_mace[1];
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, update model, check at next negedge.
  task automatic step(input string tag, input logic wr, input int addr, input logic [31:0] data,
                      input logic [7:0] txd, input logic [7:0] rxd,
                      input logic he, input logic se);
    logic active;
    bus_wr = wr; bus_addr = AW'(addr); bus_wdata = data;
    tx_done = txd; rx_done = rxd; host_err = he; stat_evt = se;
    active = ((m_txp & m_txe) != 0) || ((m_rxp & m_rxe) != 0) || ((m_macp & m_mace) != 0);
    if (wr && addr == 7) m_irq = 0;
    else if (!m_irq)     m_irq = active;
    if (wr) begin
      case (addr)
        0: m_txe = m_txe | data[7:0];
        1: m_txe = m_txe & ~data[7:0];
        2: m_rxe = m_rxe | data[7:0];
        3: m_rxe = m_rxe & ~data[7:0];
        4: m_mace = m_mace | data[1:0];
        5: m_mace = m_mace & ~data[1:0];
        8: m_macp = m_macp & ~data[1:0];
        default: begin
          if (addr >= 16 && addr < 24) m_txp[addr-16] = 1'b0;
          if (addr >= 24 && addr < 32) m_rxp[addr-24] = 1'b0;
        end
      endcase
    end
    m_txp = m_txp | txd;
    m_rxp = m_rxp | rxd;
    m_macp = m_macp | {se, he};
    @(posedge clk); #1;
    bus_wr = 0; tx_done = 0; rx_done = 0; host_err = 0; stat_evt = 0;
    bus_addr = 6'd6;
    @(negedge clk);
    check({tag, " vector"}, bus_rdata, exp_vec());
    check({tag, " irq"}, 32'(irq), 32'(m_irq));
  endtask

  task automatic rd(input string tag, input int addr, input logic [31:0] exp);
    bus_addr = AW'(addr); #1;
    check(tag, bus_rdata, exp);
    bus_addr = 6'd6;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_addr = 6'd6; #1;
    check("R1 vector", bus_rdata, 0);
    check("R1 irq", 32'(irq), 0);
    rd("R1 tx enable", 0, 0);
    rd("R1 mac enable", 4, 0);

    // R5 set/clear enables
    step("R5", 1, 0, 32'h05, 0, 0, 0, 0);
    rd("R5 tx set", 0, 32'h05);
    step("R5", 1, 1, 32'h04, 0, 0, 0, 0);
    rd("R5 tx clr", 1, 32'h01);
    step("R5", 1, 2, 32'hF0, 0, 0, 0, 0);
    rd("R5 rx set", 2, 32'hF0);
    step("R5", 1, 3, 32'hFF, 0, 0, 0, 0);
    rd("R5 rx clr all", 3, 32'h00);
    step("R5", 1, 4, 32'h3, 0, 0, 0, 0);
    rd("R5 mac set", 5, 32'h3);

    // R6 disabled channel stays pending
    step("R6 disabled event", 0, 0, 0, 8'h08, 0, 0, 0);
    step("R6 idle", 0, 0, 0, 0, 0, 0, 0);
    step("R6 enable ch3", 1, 0, 32'h08, 0, 0, 0, 0);
    step("R6 irq rises", 0, 0, 0, 0, 0, 0, 0);
    // R2 lowest channel first
    step("R2 ch7 ch0 pend", 0, 0, 0, 8'h81, 0, 0, 0);
    step("R2 enable all tx", 1, 0, 32'hFF, 0, 0, 0, 0);
    // R7 hold after acks
    step("R7 ack0", 1, 16, 0, 0, 0, 0, 0);
    step("R7 ack3", 1, 19, 0, 0, 0, 0, 0);
    step("R7 ack7", 1, 23, 0, 0, 0, 0, 0);
    step("R7 held", 0, 0, 0, 0, 0, 0, 0);
    step("R8 eoi idle", 1, 7, 32'h1234, 0, 0, 0, 0);
    step("R8 stays low", 0, 0, 0, 0, 0, 0, 0);
    // R3 receive and R8 rearm
    step("R3 rx en", 1, 2, 32'hFF, 0, 0, 0, 0);
    step("R3 rx ch5 ch2", 0, 0, 0, 0, 8'h24, 0, 0);
    step("R3 irq", 0, 0, 0, 0, 0, 0, 0);
    step("R8 eoi pending", 1, 7, 0, 0, 0, 0, 0);
    step("R8 rearmed", 0, 0, 0, 0, 0, 0, 0);
    // R9 event same cycle as ack
    step("R9 ack rx2 + event", 1, 26, 0, 0, 8'h04, 0, 0);
    step("R9 ack rx2", 1, 26, 0, 0, 0, 0, 0);
    step("R9 ack rx5", 1, 29, 0, 0, 0, 0, 0);
    // R4 / R10 MAC sources
    step("R4 host", 0, 0, 0, 0, 0, 1, 0);
    step("R4 status", 0, 0, 0, 0, 0, 0, 1);
    step("R10 ack host", 1, 8, 32'h1, 0, 0, 0, 0);
    step("R10 ack status", 1, 8, 32'h2, 0, 0, 0, 0);
    step("R5 mac clr", 1, 5, 32'h3, 0, 0, 1, 1);
    step("R6 mac reenable", 1, 4, 32'h1, 0, 0, 0, 0);
    step("R11 eoi", 1, 7, 0, 0, 0, 0, 0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int sel, addr;
      logic wr;
      logic [7:0] txd, rxd;
      sel = int'($urandom_range(0, 13));
      wr = ($urandom_range(0, 2) != 0);
      case (sel)
        0,1,2,3,4,5,7,8: addr = sel;
        6:  addr = 7;
        9,10: addr = 16 + int'($urandom_range(0, 7));
        default: addr = 24 + int'($urandom_range(0, 7));
      endcase
      txd = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      rxd = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      step("R2/R3/R7/R8/R9 random", wr, addr, $urandom,
           txd, rxd, ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule